// File: doc/BRIEF.md
# MAC Interrupt Status Aggregator

This block gathers the interrupt sources of an Ethernet MAC into one read-only 32-bit status word and a single interrupt line. Three counter-module sources arrive as already OR-reduced pending levels. Two power-management flags report a magic packet or a wake-up frame that arrived during power-down. A link level comes from the RGMII interface. The status word is rebuilt from these inputs on every clock. The interrupt line is the OR of every status bit whose mask bit is 0.

The counter bits follow their sources, with a summary bit over all three. The power-management bit is held by a small state machine. It has three states. PM_IDLE goes to PM_PEND when either flag is high. PM_PEND goes to PM_DRAIN when the power-management register is read. PM_DRAIN goes back to PM_IDLE once both flags are low. The link bit is held by a second state machine with two states. LNK_QUIET goes to LNK_PEND when the sampled link level changes. LNK_PEND goes back to LNK_QUIET when the RGMII status register is read, unless a new change arrives in that same cycle. Reads and writes of the status word itself change nothing.

Top module: `mac_irq_agg`

## Requirements
- R1: While reset is asserted, `status` is all zero and `irq` is 0.
- R2: Status bits 7, 6 and 5 equal `cnt_pend[2]`, `cnt_pend[1]` and `cnt_pend[0]` as sampled at the previous clock edge. Before that edge they do not change.
- R3: Status bit 4 is 1 exactly when at least one of bits 7:5 is 1.
- R4: Status bit 3 becomes 1 one clock after `pm_magic` or `pm_wake` is high.
- R5: Once status bit 3 is set, it returns to 0 only after a `pm_rd` strobe and then a clock at which both flags are low. Flags that fall without a read leave it set, and so does a read while a flag is still high.
- R6: Status bit 0 becomes 1 one clock after `link_up` differs from its value at the previous edge. Rising and falling changes both count.
- R7: Status bit 0 stays set until a cycle in which `rgmii_rd` is high. It then clears at that edge, unless `link_up` changes in the same cycle, in which case it stays set.
- R8: Status bits 31:8 and 2:1 always read 0.
- R9: `st_rd`, `st_wr` and `st_wdata` have no effect on `status` or `irq`.
- R10: `irq` is 1 exactly when some status bit i is 1 while `irq_mask[i]` is 0. The mask bits sit at the same positions as the status bits.
- R11: The link level present when reset is released is taken as the starting value and does not set bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_pend | input | NUM_CNT | Counter-module pending levels: [0] receive, [1] transmit, [2] receive checksum offload |
| pm_magic | input | 1 | Magic-packet received flag from power management |
| pm_wake | input | 1 | Wake-up-frame received flag from power management |
| pm_rd | input | 1 | Read strobe of the power-management register |
| link_up | input | 1 | Link status from the RGMII interface |
| rgmii_rd | input | 1 | Read strobe of the RGMII status register |
| st_rd | input | 1 | Read strobe of this status register (no side effect) |
| st_wr | input | 1 | Write strobe of this status register (ignored) |
| st_wdata | input | STAT_W | Write data (ignored) |
| irq_mask | input | STAT_W | Mask, 1 blocks the status bit at the same position |
| status | output | STAT_W | Interrupt status word |
| irq | output | 1 | Masked interrupt output |

## Verification
The counter sources are driven one at a time and then in overlapping combinations that are withdrawn one by one. This separates a wrong bit position from a wrong summary term. The power-management flags are dropped without a read, read while still high, and read and dropped together. Each of these distinguishes "clear on read" from "clear when flags fall" from the required read-then-fall order. The link input is toggled in both directions, including a change in the same cycle as a clearing read and a level already high at reset release. Masking is tried with single bits and all-ones patterns against several active sources, and the write and read strobes are pulsed with all-zero and all-one data.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;

    typedef enum logic [1:0] {
        PM_IDLE  = 2'd0,
        PM_PEND  = 2'd1,
        PM_DRAIN = 2'd2
    } pm_state_e;

    typedef enum logic {
        LNK_QUIET = 1'b0,
        LNK_PEND  = 1'b1
    } lnk_state_e;

    localparam int ST_LINK     = 0;
    localparam int ST_PMT      = 3;
    localparam int ST_CNT_SUM  = 4;
    localparam int ST_CNT_BASE = 5;

endpackage

// File: rtl/mac_irq_cnt_sum.sv
module mac_irq_cnt_sum #(
    parameter int NUM_CNT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] src_pend,
    output logic [NUM_CNT-1:0] pend_q,
    output logic               any_q
);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else begin
                pend_q[i] <= src_pend[i];
            end
        end
    end

    assign any_q = |pend_q;

endmodule

// File: rtl/mac_irq_pm_track.sv
module mac_irq_pm_track
    import mac_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic magic_flag,
    input  logic wake_flag,
    input  logic pm_reg_rd,
    output logic pend
);

    pm_state_e st_q, st_d;
    logic      flag_any;

    assign flag_any = magic_flag | wake_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PM_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PM_IDLE:  if (flag_any)  st_d = PM_PEND;
            PM_PEND:  if (pm_reg_rd) st_d = PM_DRAIN;
            PM_DRAIN: if (!flag_any) st_d = PM_IDLE;
            default:                 st_d = PM_IDLE;
        endcase
    end

    always_comb begin
        pend = (st_q != PM_IDLE);
    end

endmodule

// File: rtl/mac_irq_link_det.sv
module mac_irq_link_det
    import mac_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_in,
    input  logic clr_rd,
    output logic pend
);

    lnk_state_e st_q, st_d;
    logic       link_q;
    logic       armed_q;
    logic       changed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            link_q  <= link_in;
            armed_q <= 1'b1;
        end
    end

    assign changed = armed_q && (link_in != link_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LNK_QUIET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LNK_QUIET: if (changed)            st_d = LNK_PEND;
            LNK_PEND:  if (clr_rd && !changed) st_d = LNK_QUIET;
        endcase
    end

    always_comb begin
        pend = (st_q == LNK_PEND);
    end

endmodule

// File: rtl/mac_irq_agg.sv
module mac_irq_agg
    import mac_irq_pkg::*;
#(
    parameter int STAT_W  = 32,
    parameter int NUM_CNT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] cnt_pend,
    input  logic               pm_magic,
    input  logic               pm_wake,
    input  logic               pm_rd,
    input  logic               link_up,
    input  logic               rgmii_rd,
    input  logic               st_rd,
    input  logic               st_wr,
    input  logic [STAT_W-1:0]  st_wdata,
    input  logic [STAT_W-1:0]  irq_mask,
    output logic [STAT_W-1:0]  status,
    output logic               irq
);

    logic [NUM_CNT-1:0] cnt_bits;
    logic               cnt_any;
    logic               pm_bit;
    logic               link_bit;
    logic               unused_acc;

    // The status word is read-only and reading it has no side effect.
    assign unused_acc = ^{st_rd, st_wr, st_wdata};

    mac_irq_cnt_sum #(
        .NUM_CNT (NUM_CNT)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_pend (cnt_pend),
        .pend_q   (cnt_bits),
        .any_q    (cnt_any)
    );

    mac_irq_pm_track u_pm (
        .clk        (clk),
        .rst_n      (rst_n),
        .magic_flag (pm_magic),
        .wake_flag  (pm_wake),
        .pm_reg_rd  (pm_rd),
        .pend       (pm_bit)
    );

    mac_irq_link_det u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_in (link_up),
        .clr_rd  (rgmii_rd),
        .pend    (link_bit)
    );

    always_comb begin
        status                          = '0;
        status[ST_CNT_BASE +: NUM_CNT]  = cnt_bits;
        status[ST_CNT_SUM]              = cnt_any;
        status[ST_PMT]                  = pm_bit;
        status[ST_LINK]                 = link_bit;
    end

    assign irq = |(status & ~irq_mask);

endmodule

// File: rtl/mac_irq_agg_chk.sv
module mac_irq_agg_chk
    import mac_irq_pkg::*;
#(
    parameter int STAT_W  = 32,
    parameter int NUM_CNT = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CNT-1:0] cnt_pend,
    input logic               pm_magic,
    input logic               pm_wake,
    input logic               link_up,
    input logic               rgmii_rd,
    input logic [STAT_W-1:0]  irq_mask,
    input logic [STAT_W-1:0]  status,
    input logic               irq
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        AST_CNT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q != 2'd0) |=> (status[ST_CNT_BASE+i] == $past(cnt_pend[i]))); // R2
    end

    AST_SUM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_CNT_SUM] == (|status[ST_CNT_BASE +: NUM_CNT])); // R3

    AST_PM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_magic || pm_wake) |=> status[ST_PMT]); // R4

    AST_PM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_PMT] && (pm_magic || pm_wake)) |=> status[ST_PMT]); // R5

    AST_LINK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd2) && (link_up != $past(link_up))) |=> status[ST_LINK]); // R6

    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_LINK] && !rgmii_rd) |=> status[ST_LINK]); // R7

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_W-1:ST_CNT_BASE+NUM_CNT] == '0) && (status[ST_PMT-1:ST_LINK+1] == '0)); // R8

    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (&irq_mask) |-> !irq); // R10

endmodule

bind mac_irq_agg mac_irq_agg_chk #(
    .STAT_W  (STAT_W),
    .NUM_CNT (NUM_CNT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_pend (cnt_pend),
    .pm_magic (pm_magic),
    .pm_wake  (pm_wake),
    .link_up  (link_up),
    .rgmii_rd (rgmii_rd),
    .irq_mask (irq_mask),
    .status   (status),
    .irq      (irq)
);

// File: tb/mac_irq_agg_test.sv
`timescale 1ns/1ps
module mac_irq_agg_test;

    logic        clk;
    logic        rst_n;
    logic [2:0]  cnt_pend;
    logic        pm_magic;
    logic        pm_wake;
    logic        pm_rd;
    logic        link_up;
    logic        rgmii_rd;
    logic        st_rd;
    logic        st_wr;
    logic [31:0] st_wdata;
    logic [31:0] irq_mask;
    logic [31:0] status;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    mac_irq_agg uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_pend (cnt_pend),
        .pm_magic (pm_magic),
        .pm_wake  (pm_wake),
        .pm_rd    (pm_rd),
        .link_up  (link_up),
        .rgmii_rd (rgmii_rd),
        .st_rd    (st_rd),
        .st_wr    (st_wr),
        .st_wdata (st_wdata),
        .irq_mask (irq_mask),
        .status   (status),
        .irq      (irq)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        link_up = 1'b1;
        step(2);
        chk("R1", "status in reset", status, 32'h0);
        chk("R1", "irq in reset", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        step(3);
        chk("R11", "link high at release", status, 32'h0);
    endtask

    task automatic t_cnt_single();
        for (int i = 0; i < 3; i++) begin
            cnt_pend = 3'(1 << i);
            chk("R2", "before edge", status, 32'h0);
            step(1);
            chk("R2", "single source", status, (32'h1 << (5 + i)) | 32'h10);
            cnt_pend = 3'b000;
            step(1);
            chk("R2", "source dropped", status, 32'h0);
        end
    endtask

    task automatic t_summary();
        cnt_pend = 3'b111;
        step(1);
        chk("R3", "all sources", status, 32'hF0);
        cnt_pend = 3'b011;
        step(1);
        chk("R3", "drop checksum src", status, 32'h70);
        cnt_pend = 3'b010;
        step(1);
        chk("R3", "only transmit", status, 32'h50);
        cnt_pend = 3'b000;
        step(1);
        chk("R3", "all clear", status, 32'h0);
    endtask

    task automatic t_pm();
        pm_magic = 1'b1;
        step(1);
        chk("R4", "magic sets bit3", status, 32'h08);
        pm_magic = 1'b0;
        step(2);
        chk("R5", "flag fell without read", status, 32'h08);
        pm_wake = 1'b1;
        pm_rd = 1'b1;
        step(1);
        pm_rd = 1'b0;
        step(2);
        chk("R5", "read with flag high", status, 32'h08);
        pm_wake = 1'b0;
        step(1);
        chk("R5", "flags low after read", status, 32'h0);
        pm_wake = 1'b1;
        step(1);
        chk("R4", "wake sets bit3", status, 32'h08);
        pm_wake = 1'b0;
        pm_rd = 1'b1;
        step(1);
        pm_rd = 1'b0;
        chk("R5", "read and fall together, one edge", status, 32'h08);
        step(1);
        chk("R5", "read and fall together, cleared", status, 32'h0);
    endtask

    task automatic t_link();
        link_up = 1'b0;
        step(1);
        chk("R6", "falling change", status, 32'h01);
        step(3);
        chk("R7", "held without read", status, 32'h01);
        pm_rd = 1'b1;
        step(1);
        pm_rd = 1'b0;
        chk("R7", "other read leaves bit0", status, 32'h01);
        rgmii_rd = 1'b1;
        step(1);
        rgmii_rd = 1'b0;
        chk("R7", "cleared by read", status, 32'h0);
        link_up = 1'b1;
        step(1);
        chk("R6", "rising change", status, 32'h01);
        rgmii_rd = 1'b1;
        link_up = 1'b0;
        step(1);
        rgmii_rd = 1'b0;
        chk("R7", "change during read", status, 32'h01);
        step(1);
        chk("R7", "still set", status, 32'h01);
        rgmii_rd = 1'b1;
        step(1);
        rgmii_rd = 1'b0;
        chk("R7", "final clear", status, 32'h0);
    endtask

    task automatic t_mask();
        cnt_pend = 3'b010;
        step(1);
        chk("R10", "status for mask", status, 32'h50);
        irq_mask = 32'h0;
        step(0);
        chk("R10", "no mask", {31'd0, irq}, 32'h1);
        irq_mask = 32'h50;
        step(0);
        chk("R10", "both masked", {31'd0, irq}, 32'h0);
        irq_mask = 32'h40;
        step(0);
        chk("R10", "summary unmasked", {31'd0, irq}, 32'h1);
        irq_mask = 32'hFFFF_FFFF;
        step(0);
        chk("R10", "all masked", {31'd0, irq}, 32'h0);
        irq_mask = 32'h50;
        link_up = 1'b1;
        step(1);
        chk("R10", "link bit unmasked", {31'd0, irq}, 32'h1);
        rgmii_rd = 1'b1;
        cnt_pend = 3'b000;
        step(1);
        rgmii_rd = 1'b0;
        irq_mask = 32'h0;
        step(0);
        chk("R10", "nothing pending", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_readonly();
        cnt_pend = 3'b001;
        step(1);
        st_wr = 1'b1;
        st_rd = 1'b1;
        st_wdata = 32'h0;
        step(1);
        chk("R9", "write zeros", status, 32'h30);
        st_wdata = 32'hFFFF_FFFF;
        step(1);
        st_wr = 1'b0;
        st_rd = 1'b0;
        chk("R9", "write ones", status, 32'h30);
        chk("R9", "irq after writes", {31'd0, irq}, 32'h1);
        chk("R8", "reserved zero", status & 32'hFFFF_FF06, 32'h0);
        cnt_pend = 3'b000;
        step(1);
        chk("R9", "source still governs", status, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        cnt_pend = 3'b000;
        pm_magic = 1'b0;
        pm_wake = 1'b0;
        pm_rd = 1'b0;
        link_up = 1'b0;
        rgmii_rd = 1'b0;
        st_rd = 1'b0;
        st_wr = 1'b0;
        st_wdata = 32'h0;
        irq_mask = 32'h0;
        step(1);
        t_reset();
        t_cnt_single();
        t_summary();
        t_pm();
        t_link();
        t_mask();
        t_readonly();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule